// File: doc/BRIEF.md
# Dual-Lane Load Broadcast Steering

This block sits between the memory read buses and the register files of two parallel processing lanes, a primary lane and a secondary lane. Each cycle it may accept one load from the data-memory bus and one from the program-memory bus. Every load carries a destination register number, the number of the index register that addressed it, and the loaded data word. The block decides which lanes each load writes. It then presents one registered write port per bus per lane.

The secondary lane is written in two cases. The first is broadcasting: the broadcast enable is set and the load was addressed through the designated index register of its bus. The second is paired-lane mode, which is on. A broadcast load writes the same register number with the same data in both lanes, and it does so whatever the paired-lane mode bit says. The address generator behind the data bus owns index registers 0 to 7. The one behind the program bus owns index registers 8 to 15. When both loads in a cycle target the same register number of a lane, only the program-memory load writes that lane.

Top module: `lane_bcast_ctrl`

## Requirements
- R1: All write enables are low while rst_ni is low. Every output reflects the inputs sampled at the previous rising clock edge, so it changes exactly one cycle after the load is presented.
- R2: A valid load always writes the primary lane at its register number with its data. The only exception is a data-memory load that loses a collision under R10.
- R3: With the broadcast enable set, a data-memory load whose index number is 1 also writes the secondary lane, at the same register number and with the same data.
- R4: With the broadcast enable set, a program-memory load whose index number is 9 also writes the secondary lane, at the same register number and with the same data.
- R5: Index numbers other than 1 on the data bus, and other than 9 on the program bus, never cause a secondary-lane write while paired-lane mode is off. This also covers index 9 on the data bus and index 1 on the program bus.
- R6: The paired-lane mode bit does not change a broadcast. A qualifying load under R3 or R4 writes the secondary lane whether the bit is 0 or 1.
- R7: With paired-lane mode on, every valid load writes the secondary lane as well, whatever its index number.
- R8: With the broadcast enable off and paired-lane mode off, the secondary lane is never written, including by loads through index 1 or 9.
- R9: A data load and a program load in the same cycle are each steered independently. Both can broadcast together when their register numbers differ.
- R10: When both loads would write the same register number in one lane, only the program-memory load writes that lane. The data-memory write enable for that lane is low.
- R11: A cycle with no valid load produces no write enable in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcast_en_i | input | 1 | Broadcast enable |
| pair_mode_i | input | 1 | Paired-lane mode |
| dm_vld_i | input | 1 | Data-memory load valid |
| dm_reg_i | input | 4 | Data-memory load destination register |
| dm_idx_i | input | 4 | Index register number used by the data-memory load |
| dm_data_i | input | 32 | Data-memory load data |
| pm_vld_i | input | 1 | Program-memory load valid |
| pm_reg_i | input | 4 | Program-memory load destination register |
| pm_idx_i | input | 4 | Index register number used by the program-memory load |
| pm_data_i | input | 32 | Program-memory load data |
| pri_dm_we_o | output | 1 | Primary lane, data-bus write enable |
| pri_dm_addr_o | output | 4 | Primary lane, data-bus write register |
| pri_dm_data_o | output | 32 | Primary lane, data-bus write data |
| pri_pm_we_o | output | 1 | Primary lane, program-bus write enable |
| pri_pm_addr_o | output | 4 | Primary lane, program-bus write register |
| pri_pm_data_o | output | 32 | Primary lane, program-bus write data |
| sec_dm_we_o | output | 1 | Secondary lane, data-bus write enable |
| sec_dm_addr_o | output | 4 | Secondary lane, data-bus write register |
| sec_dm_data_o | output | 32 | Secondary lane, data-bus write data |
| sec_pm_we_o | output | 1 | Secondary lane, program-bus write enable |
| sec_pm_addr_o | output | 4 | Secondary lane, program-bus write register |
| sec_pm_data_o | output | 32 | Secondary lane, program-bus write data |

## Verification
The assertions check the following on every cycle:
- a program load always reaches the primary lane with its data one cycle later;
- a qualifying broadcast reaches the secondary lane;
- the secondary lane stays silent with both mode bits clear;
- no lane ever sees two writes to one register;
- an idle cycle produces no writes.

Only the bench's sweep shows the full steering decision. It covers every combination of the two mode bits, both valid bits, all sixteen index numbers on each bus, and colliding or distinct register numbers. It also shows that the non-designated index numbers stay single-lane, and which bus wins each lane in a collision.

// File: rtl/lane_bcast_pkg.sv
package lane_bcast_pkg;
  localparam int unsigned NLANE = 2;
  localparam int unsigned NBUS  = 2;

  typedef enum logic {
    BUS_DM = 1'b0,
    BUS_PM = 1'b1
  } bus_e;

  typedef enum logic {
    LANE_PRI = 1'b0,
    LANE_SEC = 1'b1
  } lane_e;
endpackage

// File: rtl/lane_bcast_qual.sv
// Decides which lanes one load targets.
module lane_bcast_qual #(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned BCAST_IDX = 1
) (
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bcast_en_i,
  input  logic             pair_mode_i,
  output logic [1:0]       lane_sel_o
);
  logic bcast_hit;

  // broadcast keys off the index register only; pair mode is an independent path
  assign bcast_hit = bcast_en_i && (idx_i == IDX_W'(BCAST_IDX));

  always_comb begin
    lane_sel_o[lane_bcast_pkg::LANE_PRI] = vld_i;
    lane_sel_o[lane_bcast_pkg::LANE_SEC] = vld_i && (bcast_hit || pair_mode_i);
  end
endmodule

// File: rtl/lane_bcast_arb.sv
// Per-lane collision resolution: program bus wins on equal register number.
module lane_bcast_arb #(
  parameter int unsigned REG_W = 4
) (
  input  logic             dm_req_i,
  input  logic             pm_req_i,
  input  logic [REG_W-1:0] dm_reg_i,
  input  logic [REG_W-1:0] pm_reg_i,
  output logic             dm_we_o,
  output logic             pm_we_o
);
  logic clash;

  assign clash   = pm_req_i && (dm_reg_i == pm_reg_i);
  assign dm_we_o = dm_req_i && !clash;
  assign pm_we_o = pm_req_i;
endmodule

// File: rtl/lane_bcast_wreg.sv
// One registered write port.
module lane_bcast_wreg #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              we_o,
  output logic [REG_W-1:0]  addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= we_i;
      if (we_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/lane_bcast_ctrl.sv
module lane_bcast_ctrl
  import lane_bcast_pkg::*;
#(
  parameter int unsigned REG_W        = 4,
  parameter int unsigned IDX_W        = 4,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned BCAST_DM_IDX = 1,
  parameter int unsigned BCAST_PM_IDX = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bcast_en_i,
  input  logic              pair_mode_i,
  input  logic              dm_vld_i,
  input  logic [REG_W-1:0]  dm_reg_i,
  input  logic [IDX_W-1:0]  dm_idx_i,
  input  logic [DATA_W-1:0] dm_data_i,
  input  logic              pm_vld_i,
  input  logic [REG_W-1:0]  pm_reg_i,
  input  logic [IDX_W-1:0]  pm_idx_i,
  input  logic [DATA_W-1:0] pm_data_i,
  output logic              pri_dm_we_o,
  output logic [REG_W-1:0]  pri_dm_addr_o,
  output logic [DATA_W-1:0] pri_dm_data_o,
  output logic              pri_pm_we_o,
  output logic [REG_W-1:0]  pri_pm_addr_o,
  output logic [DATA_W-1:0] pri_pm_data_o,
  output logic              sec_dm_we_o,
  output logic [REG_W-1:0]  sec_dm_addr_o,
  output logic [DATA_W-1:0] sec_dm_data_o,
  output logic              sec_pm_we_o,
  output logic [REG_W-1:0]  sec_pm_addr_o,
  output logic [DATA_W-1:0] sec_pm_data_o
);
  logic [NBUS-1:0][1:0]                    bus_sel;   // [bus][lane]
  logic [NBUS-1:0][REG_W-1:0]              bus_reg;
  logic [NBUS-1:0][DATA_W-1:0]             bus_data;
  logic [NLANE-1:0][NBUS-1:0]              we_d;
  logic [NLANE-1:0][NBUS-1:0]              we_q;
  logic [NLANE-1:0][NBUS-1:0][REG_W-1:0]   addr_q;
  logic [NLANE-1:0][NBUS-1:0][DATA_W-1:0]  data_q;

  assign bus_reg[BUS_DM]  = dm_reg_i;
  assign bus_reg[BUS_PM]  = pm_reg_i;
  assign bus_data[BUS_DM] = dm_data_i;
  assign bus_data[BUS_PM] = pm_data_i;

  lane_bcast_qual #(.IDX_W(IDX_W), .BCAST_IDX(BCAST_DM_IDX)) u_qual_dm (
    .vld_i       (dm_vld_i),
    .idx_i       (dm_idx_i),
    .bcast_en_i  (bcast_en_i),
    .pair_mode_i (pair_mode_i),
    .lane_sel_o  (bus_sel[BUS_DM])
  );

  lane_bcast_qual #(.IDX_W(IDX_W), .BCAST_IDX(BCAST_PM_IDX)) u_qual_pm (
    .vld_i       (pm_vld_i),
    .idx_i       (pm_idx_i),
    .bcast_en_i  (bcast_en_i),
    .pair_mode_i (pair_mode_i),
    .lane_sel_o  (bus_sel[BUS_PM])
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    lane_bcast_arb #(.REG_W(REG_W)) u_arb (
      .dm_req_i (bus_sel[BUS_DM][l]),
      .pm_req_i (bus_sel[BUS_PM][l]),
      .dm_reg_i (dm_reg_i),
      .pm_reg_i (pm_reg_i),
      .dm_we_o  (we_d[l][BUS_DM]),
      .pm_we_o  (we_d[l][BUS_PM])
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
      lane_bcast_wreg #(.REG_W(REG_W), .DATA_W(DATA_W)) u_wreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (we_d[l][b]),
        .addr_i (bus_reg[b]),
        .data_i (bus_data[b]),
        .we_o   (we_q[l][b]),
        .addr_o (addr_q[l][b]),
        .data_o (data_q[l][b])
      );
    end

    AST_NO_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_q[l][BUS_DM] && we_q[l][BUS_PM] && addr_q[l][BUS_DM] == addr_q[l][BUS_PM])); // R10
  end

  assign pri_dm_we_o   = we_q[LANE_PRI][BUS_DM];
  assign pri_dm_addr_o = addr_q[LANE_PRI][BUS_DM];
  assign pri_dm_data_o = data_q[LANE_PRI][BUS_DM];
  assign pri_pm_we_o   = we_q[LANE_PRI][BUS_PM];
  assign pri_pm_addr_o = addr_q[LANE_PRI][BUS_PM];
  assign pri_pm_data_o = data_q[LANE_PRI][BUS_PM];
  assign sec_dm_we_o   = we_q[LANE_SEC][BUS_DM];
  assign sec_dm_addr_o = addr_q[LANE_SEC][BUS_DM];
  assign sec_dm_data_o = data_q[LANE_SEC][BUS_DM];
  assign sec_pm_we_o   = we_q[LANE_SEC][BUS_PM];
  assign sec_pm_addr_o = addr_q[LANE_SEC][BUS_PM];
  assign sec_pm_data_o = data_q[LANE_SEC][BUS_PM];

  AST_PM_PRI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_vld_i |=> (pri_pm_we_o && pri_pm_data_o == $past(pm_data_i))); // R2

  AST_BCAST_PM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_en_i && pm_vld_i && pm_idx_i == IDX_W'(BCAST_PM_IDX))
      |=> (sec_pm_we_o && sec_pm_addr_o == $past(pm_reg_i))); // R6

  AST_BCAST_DM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_en_i && dm_vld_i && dm_idx_i == IDX_W'(BCAST_DM_IDX)
      && !(pm_vld_i && pm_reg_i == dm_reg_i))
      |=> (sec_dm_we_o && sec_dm_data_o == $past(dm_data_i))); // R3

  AST_SEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bcast_en_i && !pair_mode_i) |=> !(sec_dm_we_o || sec_pm_we_o)); // R8

  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dm_vld_i && !pm_vld_i) |=> ($countones({pri_dm_we_o, pri_pm_we_o, sec_dm_we_o, sec_pm_we_o}) == 0)); // R11

  AST_SEC_PM_HAS_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pm_we_o |-> pri_pm_we_o); // R7
endmodule

// File: tb/lane_bcast_ctrl_tb.sv
module lane_bcast_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bcast_en = 1'b0, pair_mode = 1'b0;
  logic        dm_vld = 1'b0, pm_vld = 1'b0;
  logic [3:0]  dm_reg = '0, dm_idx = '0, pm_reg = '0, pm_idx = '0;
  logic [31:0] dm_data = '0, pm_data = '0;
  logic        pri_dm_we, pri_pm_we, sec_dm_we, sec_pm_we;
  logic [3:0]  pri_dm_addr, pri_pm_addr, sec_dm_addr, sec_pm_addr;
  logic [31:0] pri_dm_data, pri_pm_data, sec_dm_data, sec_pm_data;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  lane_bcast_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bcast_en_i(bcast_en), .pair_mode_i(pair_mode),
    .dm_vld_i(dm_vld), .dm_reg_i(dm_reg), .dm_idx_i(dm_idx), .dm_data_i(dm_data),
    .pm_vld_i(pm_vld), .pm_reg_i(pm_reg), .pm_idx_i(pm_idx), .pm_data_i(pm_data),
    .pri_dm_we_o(pri_dm_we), .pri_dm_addr_o(pri_dm_addr), .pri_dm_data_o(pri_dm_data),
    .pri_pm_we_o(pri_pm_we), .pri_pm_addr_o(pri_pm_addr), .pri_pm_data_o(pri_pm_data),
    .sec_dm_we_o(sec_dm_we), .sec_dm_addr_o(sec_dm_addr), .sec_dm_data_o(sec_dm_data),
    .sec_pm_we_o(sec_pm_we), .sec_pm_addr_o(sec_pm_addr), .sec_pm_data_o(sec_pm_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic e_pdm, e_ppm, e_sdm, e_spm, rq_sdm, rq_spm;
    string t_sdm, t_spm;
    repeat (3) @(negedge clk);
    chk("R1 reset pri_dm_we", 64'(pri_dm_we), 64'd0);
    chk("R1 reset pri_pm_we", 64'(pri_pm_we), 64'd0);
    chk("R1 reset sec_dm_we", 64'(sec_dm_we), 64'd0);
    chk("R1 reset sec_pm_we", 64'(sec_pm_we), 64'd0);
    rst_ni = 1'b1;
    // present a load; outputs must not move before the clock edge
    dm_vld = 1'b1; pm_vld = 1'b1; pair_mode = 1'b1; dm_reg = 4'd2; pm_reg = 4'd3;
    #1;
    chk("R1 no comb path", 64'({pri_dm_we, pri_pm_we, sec_dm_we, sec_pm_we}), 64'd0);
    @(negedge clk);
    chk("R1 one-cycle latency", 64'({pri_dm_we, pri_pm_we, sec_dm_we, sec_pm_we}), 64'hF);

    for (int k = 0; k < 8192; k++) begin
      logic same;
      same      = k[0];
      pm_idx    = k[4:1];
      dm_idx    = k[8:5];
      pm_vld    = k[9];
      dm_vld    = k[10];
      pair_mode = k[11];
      bcast_en  = k[12];
      dm_reg    = 4'(k * 7);
      pm_reg    = same ? dm_reg : dm_reg ^ 4'h5;
      dm_data   = {16'hD0D0, 16'(k)};
      pm_data   = {16'hB0B0, 16'(k)};

      rq_sdm = dm_vld && ((bcast_en && dm_idx == 4'd1) || pair_mode);
      rq_spm = pm_vld && ((bcast_en && pm_idx == 4'd9) || pair_mode);
      e_ppm  = pm_vld;
      e_pdm  = dm_vld && !(pm_vld && same);
      e_spm  = rq_spm;
      e_sdm  = rq_sdm && !(rq_spm && same);

      if (!dm_vld) t_sdm = "R11 sec_dm";
      else if (rq_sdm && rq_spm && same) t_sdm = "R10 sec_dm";
      else if (bcast_en && dm_idx == 4'd1) t_sdm = pair_mode ? "R6 sec_dm" : (rq_spm ? "R9 sec_dm" : "R3 sec_dm");
      else if (pair_mode) t_sdm = "R7 sec_dm";
      else if (!bcast_en) t_sdm = "R8 sec_dm";
      else t_sdm = "R5 sec_dm";

      if (!pm_vld) t_spm = "R11 sec_pm";
      else if (bcast_en && pm_idx == 4'd9) t_spm = pair_mode ? "R6 sec_pm" : (rq_sdm ? "R9 sec_pm" : "R4 sec_pm");
      else if (pair_mode) t_spm = "R7 sec_pm";
      else if (!bcast_en) t_spm = "R8 sec_pm";
      else t_spm = "R5 sec_pm";

      @(negedge clk);
      chk(pm_vld ? "R2 pri_pm_we" : "R11 pri_pm_we", 64'(pri_pm_we), 64'(e_ppm));
      chk((dm_vld && pm_vld && same) ? "R10 pri_dm_we" : (dm_vld ? "R2 pri_dm_we" : "R11 pri_dm_we"),
          64'(pri_dm_we), 64'(e_pdm));
      chk(t_sdm, 64'(sec_dm_we), 64'(e_sdm));
      chk(t_spm, 64'(sec_pm_we), 64'(e_spm));
      if (e_ppm) chk("R2 pri_pm port", {28'd0, pri_pm_addr, pri_pm_data}, {28'd0, pm_reg, pm_data});
      if (e_pdm) chk("R2 pri_dm port", {28'd0, pri_dm_addr, pri_dm_data}, {28'd0, dm_reg, dm_data});
      if (e_sdm) chk("R3 sec_dm port", {28'd0, sec_dm_addr, sec_dm_data}, {28'd0, dm_reg, dm_data});
      if (e_spm) chk("R4 sec_pm port", {28'd0, sec_pm_addr, sec_pm_data}, {28'd0, pm_reg, pm_data});
    end

    rst_ni = 1'b0;
    #1;
    chk("R1 async reset", 64'({pri_dm_we, pri_pm_we, sec_dm_we, sec_pm_we}), 64'd0);
    summary();
  end
endmodule